// File: doc/BRIEF.md
# Dual Bank Window Address Translator

This block sits between the host memory port and a display memory of up to 1 MB. A host cycle that falls inside the selected decode window is turned into a display-memory cycle. The window-relative address has an 8-bit bank offset added to its page field, bits 12 to 19. Each bank view therefore starts on a 4 KB boundary, and the sum wraps within the 1 MB memory. Host cycles outside the window produce no memory cycle.

Two bank offsets, A and B, are kept. With splitting disabled, bank A serves every access. With splitting enabled, the bank is picked in one of two ways. In direction mode, reads use bank A and writes use bank B. In address mode, the lower half of the window uses bank B and the upper half uses bank A.

The offsets and the configuration sit behind a small indexed register port. A guard register gates every update with a 3-bit unlock key. A protect bit in the guard register hides the values of the other registers from reads.

Top module: `bankwin_xlate`

## Requirements
- R1: Config bits 3:2 select the decode window. 0 selects A0000h-BFFFFh, or A0000h-AFFFFh when config bit 4 is set. 1 selects 0-3FFFFh, 2 selects 0-7FFFFh and 3 selects 0-FFFFFh. One cycle after a host request, `m_req` is high exactly when the address was inside the window.
- R2: One cycle after an accepted host request, `m_addr` = (rel + offset*4096) mod 2^20 and `m_we` equals the request's `h_we`. Here rel is `h_addr` minus A0000h for window 0, and `h_addr` itself for the other windows.
- R3: While config bit 0 (split enable) is clear, every access uses bank A (`m_bank` = 0).
- R4: While split enable and config bit 1 (direction mode) are both set, reads use bank A and writes use bank B (`m_bank` = 1).
- R5: While split enable is set and direction mode is clear, addresses in the lower half of the window use bank B and addresses in the upper half use bank A. In the 64 KB window the halves divide at A8000h; in the 128 KB window they divide at B0000h.
- R6: The register indices are 0 for bank A, 1 for bank B, 2 for config (bits 4:0) and 3 for guard. Writes to indices 0 to 2 take effect only while guard bits 2:0 hold the value 5. The guard register itself can always be written.
- R7: `r_rdata` is registered and answers one cycle after `r_rd`. Indices 0 to 2 return their value only while the key is 5 and guard bit 4 (protect) is clear, and 00h otherwise. The guard register always reads as {3'b0, protect, 1'b0, key}. Indices 4 to 7 read 00h, and `r_rdata` is 00h in any cycle without a read.
- R8: After reset, all registers are zero, so the block is locked with split disabled and window 0. No memory cycle is issued and `r_rdata` is 00h.
- R9: The page sum wraps modulo 1 MB. For example, an offset of FFh moves page 01h to page 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host memory cycle valid |
| h_we | input | 1 | Host cycle is a write |
| h_addr | input | 20 | Host physical address |
| r_wr | input | 1 | Register write strobe |
| r_rd | input | 1 | Register read strobe |
| r_idx | input | 3 | Register index |
| r_wdata | input | 8 | Register write data |
| r_rdata | output | 8 | Register read data, one cycle after the read |
| m_req | output | 1 | Display memory cycle valid |
| m_we | output | 1 | Display memory cycle is a write |
| m_bank | output | 1 | Bank used: 0 = A, 1 = B |
| m_addr | output | 20 | Translated display memory address |

## Verification
On every cycle, the assertions check the following:
- every memory cycle traces back to a host request;
- the byte offset within a page and the direction are preserved;
- a single bank is used while splitting is off, and direction mode ties the bank to the direction;
- the offsets and config stay unchanged while the key is wrong;
- blocked reads return zero.

Other behaviours depend on the arithmetic and the register history, so only the bench's scenarios can show them:
- the window boundaries for each map;
- the half split at A8000h and B0000h;
- the modulo-1 MB wrap;
- that a locked write is lost for good and is still absent after unlocking.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
   localparam int ADDR_W = 20;
   localparam int DATA_W = 8;
   localparam int IDX_W  = 3;
   localparam int KEY_W  = 3;
   localparam logic [ADDR_W-1:0] LEG_BASE = 20'hA0000;

   typedef enum logic [1:0] {
      MAP_LEGACY = 2'd0,
      MAP_256K   = 2'd1,
      MAP_512K   = 2'd2,
      MAP_1M     = 2'd3
   } map_e;

   // bit4 win64, bits3:2 map, bit1 direction mode, bit0 split enable
   typedef struct packed {
      logic win64;
      map_e map;
      logic rw_mode;
      logic split;
   } cfg_t;

   localparam logic [IDX_W-1:0] IDX_BANKA = 3'd0;
   localparam logic [IDX_W-1:0] IDX_BANKB = 3'd1;
   localparam logic [IDX_W-1:0] IDX_CFG   = 3'd2;
   localparam logic [IDX_W-1:0] IDX_GUARD = 3'd3;
endpackage

// File: rtl/bankwin_regs.sv
module bankwin_regs
   import bankwin_pkg::*;
#(
   parameter int BANK_W     = 8,
   parameter int UNLOCK_KEY = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [BANK_W-1:0] bank_a,
   output logic [BANK_W-1:0] bank_b,
   output cfg_t              cfg,
   output logic              unlocked,
   output logic              protect
);
   localparam logic [KEY_W-1:0] KEY = KEY_W'(UNLOCK_KEY);

   if (BANK_W > DATA_W) begin : g_bank_too_wide
      $error("bank offset wider than register data");
   end
   if (UNLOCK_KEY >= (1 << KEY_W)) begin : g_key_range
      $error("unlock key does not fit the key field");
   end

   logic [BANK_W-1:0] bank_a_q, bank_b_q;
   cfg_t              cfg_q;
   logic [KEY_W-1:0]  key_q;
   logic              prot_q;
   logic [DATA_W-1:0] rd_val, rdata_q;
   logic              open_rd;
   logic              unused_wbits;

   assign unlocked     = (key_q == KEY);
   assign open_rd      = unlocked & ~prot_q;
   assign unused_wbits = ^{wdata[DATA_W-1:5], wdata[3]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_a_q <= '0;
         bank_b_q <= '0;
         cfg_q    <= '0;
         key_q    <= '0;
         prot_q   <= 1'b0;
      end else if (wr) begin
         unique case (idx)
            IDX_GUARD: begin
               key_q  <= wdata[KEY_W-1:0];
               prot_q <= wdata[4];
            end
            IDX_BANKA: if (unlocked) bank_a_q <= wdata[BANK_W-1:0];
            IDX_BANKB: if (unlocked) bank_b_q <= wdata[BANK_W-1:0];
            IDX_CFG:   if (unlocked) cfg_q    <= cfg_t'(wdata[4:0]);
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_val = '0;
      unique case (idx)
         IDX_GUARD: rd_val = {3'b000, prot_q, 1'b0, key_q};
         IDX_BANKA: if (open_rd) rd_val = DATA_W'(bank_a_q);
         IDX_BANKB: if (open_rd) rd_val = DATA_W'(bank_b_q);
         IDX_CFG:   if (open_rd) rd_val = DATA_W'(cfg_q);
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd ? rd_val : '0;
   end

   assign rdata   = rdata_q;
   assign bank_a  = bank_a_q;
   assign bank_b  = bank_b_q;
   assign cfg     = cfg_q;
   assign protect = prot_q;
endmodule

// File: rtl/bankwin_decode.sv
module bankwin_decode
   import bankwin_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  cfg_t              cfg,
   output logic              hit,
   output logic              use_b,
   output logic [ADDR_W-1:0] rel
);
   logic upper;

   always_comb begin
      rel   = (cfg.map == MAP_LEGACY) ? (addr - LEG_BASE) : addr;
      hit   = 1'b0;
      upper = 1'b0;
      unique case (cfg.map)
         MAP_LEGACY: begin
            if (cfg.win64) begin
               hit   = (addr[19:16] == 4'hA);
               upper = rel[15];
            end else begin
               hit   = (addr[19:17] == 3'b101);
               upper = rel[16];
            end
         end
         MAP_256K: begin hit = (addr[19:18] == 2'b00); upper = rel[17]; end
         MAP_512K: begin hit = ~addr[19];              upper = rel[18]; end
         default:  begin hit = 1'b1;                   upper = rel[19]; end
      endcase
      use_b = cfg.split & (cfg.rw_mode ? we : ~upper);
   end
endmodule

// File: rtl/bankwin_stage.sv
module bankwin_stage
   import bankwin_pkg::*;
#(
   parameter int PAGE_W  = 12,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req,
   input  logic                     we,
   input  logic                     use_b,
   input  logic [ADDR_W-1:0]        rel,
   input  logic [ADDR_W-PAGE_W-1:0] bank_a,
   input  logic [ADDR_W-PAGE_W-1:0] bank_b,
   output logic                     m_req,
   output logic                     m_we,
   output logic                     m_bank,
   output logic [ADDR_W-1:0]        m_addr
);
   localparam int BANK_W = ADDR_W - PAGE_W;

   logic [BANK_W-1:0] page_sum;
   logic [ADDR_W-1:0] addr_nx;

   assign page_sum = rel[ADDR_W-1:PAGE_W] + (use_b ? bank_b : bank_a);
   assign addr_nx  = {page_sum, rel[PAGE_W-1:0]};

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            m_req  <= 1'b0;
            m_we   <= 1'b0;
            m_bank <= 1'b0;
            m_addr <= '0;
         end else begin
            m_req  <= req;
            m_we   <= we;
            m_bank <= use_b;
            m_addr <= addr_nx;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign m_req  = req;
      assign m_we   = we;
      assign m_bank = use_b;
      assign m_addr = addr_nx;
   end
endmodule

// File: rtl/bankwin_xlate.sv
module bankwin_xlate
   import bankwin_pkg::*;
#(
   parameter int PAGE_W     = 12,
   parameter int UNLOCK_KEY = 5,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              r_wr,
   input  logic              r_rd,
   input  logic [IDX_W-1:0]  r_idx,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              m_req,
   output logic              m_we,
   output logic              m_bank,
   output logic [ADDR_W-1:0] m_addr
);
   localparam int BANK_W = ADDR_W - PAGE_W;

   if (PAGE_W < 12 || PAGE_W > 15) begin : g_page_range
      $error("PAGE_W must lie in 12..15");
   end

   logic [BANK_W-1:0] bank_a, bank_b;
   cfg_t              cfg;
   logic              unlocked, protect;
   logic              hit, use_b;
   logic [ADDR_W-1:0] rel;

   bankwin_regs #(.BANK_W(BANK_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(r_wr), .rd(r_rd), .idx(r_idx),
      .wdata(r_wdata), .rdata(r_rdata), .bank_a(bank_a), .bank_b(bank_b),
      .cfg(cfg), .unlocked(unlocked), .protect(protect)
   );

   bankwin_decode u_dec (
      .addr(h_addr), .we(h_we), .cfg(cfg), .hit(hit), .use_b(use_b), .rel(rel)
   );

   bankwin_stage #(.PAGE_W(PAGE_W), .REG_OUT(REG_OUT)) u_stage (
      .clk(clk), .rst_n(rst_n), .req(h_req & hit), .we(h_we), .use_b(use_b),
      .rel(rel), .bank_a(bank_a), .bank_b(bank_b),
      .m_req(m_req), .m_we(m_we), .m_bank(m_bank), .m_addr(m_addr)
   );
endmodule

// File: rtl/bankwin_chk.sv
module bankwin_chk
   import bankwin_pkg::*;
#(
   parameter int PAGE_W  = 12,
   parameter bit REG_OUT = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     h_req,
   input logic                     h_we,
   input logic [ADDR_W-1:0]        h_addr,
   input logic                     r_rd,
   input logic [IDX_W-1:0]         r_idx,
   input logic [DATA_W-1:0]        r_rdata,
   input logic                     m_req,
   input logic                     m_we,
   input logic                     m_bank,
   input logic [ADDR_W-1:0]        m_addr,
   input logic [ADDR_W-PAGE_W-1:0] bank_a,
   input logic [ADDR_W-PAGE_W-1:0] bank_b,
   input cfg_t                     cfg,
   input logic                     unlocked,
   input logic                     protect
);
   // R6
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(bank_a) && $stable(bank_b) && $stable(cfg));

   // R7
   rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_rd && (protect || !unlocked) && (r_idx != IDX_GUARD) |=> r_rdata == '0);

   if (REG_OUT) begin : g_lat1
      // R1
      req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_req |-> $past(h_req));

      // R2
      page_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_req |-> m_addr[PAGE_W-1:0] == $past(h_addr[PAGE_W-1:0]));

      // R2
      dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_req |-> m_we == $past(h_we));

      // R3
      single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_req && !$past(cfg.split) |-> !m_bank);

      // R4
      dir_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_req && $past(cfg.split && cfg.rw_mode) |-> m_bank == m_we);
   end
endmodule

bind bankwin_xlate bankwin_chk #(.PAGE_W(PAGE_W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
   .r_rd(r_rd), .r_idx(r_idx), .r_rdata(r_rdata), .m_req(m_req), .m_we(m_we),
   .m_bank(m_bank), .m_addr(m_addr), .bank_a(bank_a), .bank_b(bank_b),
   .cfg(cfg), .unlocked(unlocked), .protect(protect)
);

// File: tb/sim_bankwin_xlate.sv
module sim_bankwin_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0, h_we = 1'b0;
   logic [19:0] h_addr = '0;
   logic        r_wr = 1'b0, r_rd = 1'b0;
   logic [2:0]  r_idx = '0;
   logic [7:0]  r_wdata = '0;
   logic [7:0]  r_rdata;
   logic        m_req, m_we, m_bank;
   logic [19:0] m_addr;

   always #2 clk = ~clk;

   bankwin_xlate u0 (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
      .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .m_req(m_req), .m_we(m_we), .m_bank(m_bank), .m_addr(m_addr)
   );

   int n_chk = 0, n_fail = 0;
   bit live = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int ma = 0, mb = 0, mcfg = 0, mkey = 0, mprot = 0;
   bit exp_req = 0, exp_we = 0, exp_bank = 0;
   int exp_addr = 0, exp_rdata = 0;
   string bank_tag = "R3";

   always @(posedge clk) begin
      if (!rst_n) begin
         ma = 0; mb = 0; mcfg = 0; mkey = 0; mprot = 0;
         exp_req = 0; exp_rdata = 0;
      end else begin
         int lo, size, rel, a, v;
         bit split, rw, useb, hit;
         split = mcfg[0];
         rw    = mcfg[1];
         case ((mcfg >> 2) & 3)
            0: begin lo = 'hA0000; size = mcfg[4] ? 'h10000 : 'h20000; end
            1: begin lo = 0; size = 'h40000; end
            2: begin lo = 0; size = 'h80000; end
            default: begin lo = 0; size = 'h100000; end
         endcase
         a    = int'(h_addr);
         hit  = (a >= lo) && (a < lo + size);
         rel  = a - lo;
         useb = split && (rw ? h_we : (rel < size / 2));
         bank_tag = !split ? "R3" : (rw ? "R4" : "R5");
         exp_req  = h_req && hit;
         exp_we   = h_we;
         exp_bank = useb;
         exp_addr = (rel + (useb ? mb : ma) * 4096) % 'h100000;
         case (r_idx)
            3'd3: v = (mprot << 4) | mkey;
            3'd0: v = (mkey == 5 && !mprot) ? ma : 0;
            3'd1: v = (mkey == 5 && !mprot) ? mb : 0;
            3'd2: v = (mkey == 5 && !mprot) ? mcfg : 0;
            default: v = 0;
         endcase
         exp_rdata = r_rd ? v : 0;
         if (r_wr) begin
            if (r_idx == 3'd3) begin
               mkey  = r_wdata & 7;
               mprot = (r_wdata >> 4) & 1;
            end else if (mkey == 5) begin
               if (r_idx == 3'd0) ma = r_wdata;
               if (r_idx == 3'd1) mb = r_wdata;
               if (r_idx == 3'd2) mcfg = r_wdata & 'h1F;
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && live) begin
         chk(m_req === exp_req, "R1 decode", m_req, exp_req);
         if (exp_req) begin
            chk(m_addr === 20'(exp_addr), "R2 R9 address", m_addr, exp_addr);
            chk(m_we === exp_we, "R2 direction", m_we, exp_we);
            chk(m_bank === exp_bank, {bank_tag, " bank"}, m_bank, exp_bank);
         end
         chk(r_rdata === 8'(exp_rdata), "R6 R7 readback", r_rdata, exp_rdata);
      end
   end

   task automatic idle();
      @(negedge clk);
      h_req <= 0; r_wr <= 0; r_rd <= 0;
   endtask

   task automatic regw(input int idx, input int d);
      @(negedge clk);
      h_req <= 0; r_rd <= 0; r_wr <= 1; r_idx <= 3'(idx); r_wdata <= 8'(d);
   endtask

   task automatic regr(input int idx);
      @(negedge clk);
      h_req <= 0; r_wr <= 0; r_rd <= 1; r_idx <= 3'(idx);
   endtask

   task automatic host(input logic [19:0] a, input logic we);
      @(negedge clk);
      r_wr <= 0; r_rd <= 0; h_req <= 1; h_addr <= a; h_we <= we;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n <= 1'b1;
      @(negedge clk);
      // R8: idle outputs after reset, guard reads zero
      chk(m_req === 1'b0, "R8 m_req", m_req, 0);
      chk(r_rdata === 8'h00, "R8 r_rdata", r_rdata, 0);
      live = 1'b1;
      regr(3);
      idle();
      chk(r_rdata === 8'h00, "R8 guard", r_rdata, 0);
      // R3 and R1 with reset config: legacy 128K window, bank A = 0
      host(20'hA0000, 0); host(20'h9FFFF, 0); host(20'hBFFFF, 1); host(20'hC0000, 1);
      // R6: locked writes are dropped
      regw(0, 'h33); regw(2, 'h05);
      regw(3, 5); regr(0); regr(2);
      idle();
      chk(r_rdata === 8'h00, "R6 locked write dropped", r_rdata, 0);
      regw(0, 'h12); regw(1, 'h47); regw(2, 'h00);
      regr(0); regr(1); regr(2);
      // R3: split off, any address
      host(20'hA1234, 1); host(20'hB5678, 0); host(20'hAFFFF, 1);
      // R5: split, 64K legacy window, halves at A8000h
      regw(2, 'h11);
      host(20'hA0000, 0); host(20'hA7FFF, 1); host(20'hA8000, 0); host(20'hAFFFF, 1);
      host(20'hB0000, 0);
      // R5: split, 128K legacy window, halves at B0000h
      regw(2, 'h01);
      host(20'hAFFFF, 0); host(20'hB0000, 1); host(20'hBFFFF, 0);
      // R4: direction mode on 256K map
      regw(2, 'h07);
      host(20'h00100, 0); host(20'h00100, 1); host(20'h3FFFF, 1); host(20'h40000, 0);
      // R1 R5: 512K and 1M maps
      regw(2, 'h09);
      host(20'h3FFFF, 0); host(20'h40000, 0); host(20'h7FFFF, 1); host(20'h80000, 1);
      regw(2, 'h0D);
      for (int i = 0; i < 64; i++) host(20'($urandom), 1'($urandom));
      // R9: wrap with offset FFh
      regw(0, 'hFF); regw(1, 'hF0);
      host(20'hF1234, 0); host(20'hFFFFF, 0); host(20'h12345, 1);
      // random config and traffic
      for (int i = 0; i < 200; i++) begin
         if (i % 25 == 0) regw(2, int'($urandom) & 'h1F);
         if (i % 40 == 0) regw(i % 80 == 0 ? 0 : 1, int'($urandom) & 'hFF);
         host(20'($urandom), 1'($urandom));
      end
      // R7: protect hides values, guard still visible, high indices zero
      regw(3, 'h15);
      regr(0); regr(1); regr(2); regr(3); regr(5); regr(7);
      // R6: relock, config write ignored while traffic shows old mapping
      regw(3, 'h02);
      regw(2, 'h00); regw(0, 'h01);
      host(20'hA4000, 0); host(20'h54321, 1); host(20'hB8000, 1);
      regw(3, 'h05);
      regr(0); regr(2); regr(4);
      idle(); idle();
      summary();
   end
endmodule